// File: doc/BRIEF.md
# Two-Port Serial Gamepad Interface with Four-Player Adapter

This block is the console side of two serial controller ports. Each port carries two gamepads through a four-player adapter. A processor controls the block through one write port, which sets a strobe level, and two read ports, one for each controller port. Each read port presents one serial bit. The block takes the parallel button states of all four pads as inputs. On a complete strobe it captures those states and the two port-connected flags. Every later read of a port then steps that port through a fixed 24-position frame.

A frame has four parts, in this order:
- eight buttons of the port's first pad;
- eight buttons of its second pad;
- a four-bit identification code for the port;
- zero fill.

If the strobe is still high when a port is read, the read returns the live state of that port's first pad button A, and the frame does not move. If the strobe sequence was broken, the pads are not selected: reads return 0 and do not advance.

Top module: `padport_top`

## Requirements
- R1: After reset, the strobe is low and no capture has happened. Both `port_bit` outputs are 0, and reads return 0 without moving the frame.
- R2: A write with `wr_d0`=1, followed later by a write with `wr_d0`=0, is a complete strobe. The write of 0 captures all four pads and both connected flags, and restarts both frames at position 1.
- R3: Frame positions 1 to 8 return the port's first pad. Pad bit 0 is A, then B, Select, Start, Up, Down, Left, and bit 7 is Right. Each read presents the current position on `port_bit` and moves that port to the next position.
- R4: Positions 9 to 16 return the port's second pad in the same button order. Port 0 carries pads 0 and 2, and port 1 carries pads 1 and 3. Pad n occupies `pad_buttons[8n+7:8n]`.
- R5: Positions 17 to 20 return the identification code, most significant bit first. The code is 0001 for port 0 and 0010 for port 1.
- R6: If the connected flag captured for a port was 0, positions 17 to 20 return 0000.
- R7: Positions 21 to 24, and every read after the 24th, return 0. This holds until the next complete strobe.
- R8: While the strobe is high, `port_bit` follows button A of the port's first pad as it changes. Reads leave the frame at position 1.
- R9: A write of 0 while the strobe is already low makes the pads unselected, and so does a write of 1 that has not yet been followed by a write of 0. While unselected with the strobe low, reads return 0 and the frame does not advance.
- R10: Each port keeps its own position counter. Reads of one port do not move the other.
- R11: Captured values do not change when the pad inputs change after the strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Strobe register write, one-cycle pulse |
| wr_d0 | input | 1 | Data bit 0 of the strobe write |
| rd_en | input | 2 | Read pulse per port; bit p reads port p |
| pad_buttons | input | 32 | Pressed=1 state of pads 0..3, eight bits each |
| pad_present | input | 2 | Adapter connected flag per port |
| port_bit | output | 2 | Serial bit presented by each port at its current position |

## Verification
The assertions take for granted several properties of the inputs:
- every write and read is sampled once per rising clock edge;
- `rd_en` bits are pulses, so a read held high for several cycles counts as several reads;
- `rst_n` is low before the first transfer.

The stimulus keeps within these limits by changing every input only on the falling edge and holding each write or read for one cycle. Reads are never issued during the reset cycles. The pad inputs change freely, and also in the middle of a frame. The design samples them only at the capture point or as the live button A, so no timing assumption about the pads is needed.

// File: rtl/padport_pkg.sv
package padport_pkg;

    localparam int DEF_BTN_W     = 8;
    localparam int DEF_PADS_PORT = 2;
    localparam int DEF_NUM_PORTS = 2;
    localparam int DEF_SIG_W     = 4;
    localparam int DEF_FRAME_LEN = 24;

    typedef struct packed {
        logic level;
        logic armed;
    } strobe_state_t;

    // identification code of port p: one-hot, port 0 -> 0001, port 1 -> 0010
    function automatic logic [DEF_SIG_W-1:0] port_code(input int p);
        logic [DEF_SIG_W-1:0] v;
        v = '0;
        v[p] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/padport_strobe_ctl.sv
module padport_strobe_ctl
    import padport_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_d0,
    output logic strobe_hi,
    output logic armed,
    output logic latch_evt
);

    strobe_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        latch_evt = 1'b0;
        if (wr_en) begin
            if (wr_d0) begin
                st_d.level = 1'b1;
                st_d.armed = 1'b0;
            end else if (st_q.level) begin
                st_d.level = 1'b0;
                st_d.armed = 1'b1;
                latch_evt  = 1'b1;
            end else begin
                st_d.armed = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign strobe_hi = st_q.level;
    assign armed     = st_q.armed;

    // R9: a set write always leaves the pads unselected with the strobe high
    assert_set_disarms_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_d0) |=> (strobe_hi && !armed));

    // R2: a capture event leaves the pads selected with the strobe low
    assert_capture_arms_R2: assert property (@(posedge clk) disable iff (!rst_n)
        latch_evt |=> (armed && !strobe_hi));

    // R9: a clear write with the strobe already low never selects the pads
    assert_stray_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_d0 && !strobe_hi) |=> !armed);

endmodule

// File: rtl/padport_bit_sel.sv
module padport_bit_sel #(
    parameter int BTN_W     = 8,
    parameter int PADS_PORT = 2,
    parameter int SIG_W     = 4,
    parameter int FRAME_LEN = 24,
    localparam int SHADOW_W = BTN_W * PADS_PORT,
    localparam int CNT_W    = $clog2(FRAME_LEN + 1),
    localparam int SH_W     = $clog2(SHADOW_W),
    localparam int SG_W     = $clog2(SIG_W)
) (
    input  logic [SHADOW_W-1:0] shadow,
    input  logic [SIG_W-1:0]    code,
    input  logic [CNT_W-1:0]    pos,
    output logic                sel_bit
);

    localparam logic [CNT_W-1:0] SIG_FIRST = CNT_W'(SHADOW_W);
    localparam logic [CNT_W-1:0] SIG_LAST  = CNT_W'(SHADOW_W + SIG_W - 1);

    logic [SH_W-1:0] sh_idx;
    logic [SG_W-1:0] sg_idx;

    always_comb begin
        sh_idx  = SH_W'(pos);
        // most significant code bit comes first
        sg_idx  = SG_W'(SIG_LAST - pos);
        sel_bit = 1'b0;
        if (pos < SIG_FIRST) begin
            sel_bit = shadow[sh_idx];
        end else if (pos <= SIG_LAST) begin
            sel_bit = code[sg_idx];
        end
    end

endmodule

// File: rtl/padport_lane.sv
module padport_lane #(
    parameter int PORT_IDX  = 0,
    parameter int BTN_W     = 8,
    parameter int PADS_PORT = 2,
    parameter int NUM_PORTS = 2,
    parameter int SIG_W     = 4,
    parameter int FRAME_LEN = 24,
    localparam int SHADOW_W = BTN_W * PADS_PORT,
    localparam int ALL_W    = BTN_W * PADS_PORT * NUM_PORTS,
    localparam int CNT_W    = $clog2(FRAME_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ALL_W-1:0] pads_all,
    input  logic             present,
    input  logic             strobe_hi,
    input  logic             armed,
    input  logic             latch_evt,
    input  logic             rd_en,
    output logic             data_bit
);

    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_LEN);

    typedef struct packed {
        logic [CNT_W-1:0]    cnt;
        logic [SHADOW_W-1:0] shadow;
        logic                present;
    } lane_state_t;

    lane_state_t st_d, st_q;

    logic [SHADOW_W-1:0] live;
    logic [SIG_W-1:0]    code;
    logic                sel_bit;

    for (genvar k = 0; k < PADS_PORT; k++) begin : g_gather
        assign live[k*BTN_W +: BTN_W] =
            pads_all[(PORT_IDX + NUM_PORTS*k)*BTN_W +: BTN_W];
    end

    always_comb begin
        code = '0;
        if (st_q.present) begin
            code[PORT_IDX] = 1'b1;
        end
    end

    always_comb begin
        st_d = st_q;
        if (latch_evt) begin
            st_d.cnt     = '0;
            st_d.shadow  = live;
            st_d.present = present;
        end else if (strobe_hi) begin
            st_d.cnt = '0;
        end else if (armed && rd_en && (st_q.cnt < LAST_POS)) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    padport_bit_sel #(
        .BTN_W    (BTN_W),
        .PADS_PORT(PADS_PORT),
        .SIG_W    (SIG_W),
        .FRAME_LEN(FRAME_LEN)
    ) i_sel (
        .shadow (st_q.shadow),
        .code   (code),
        .pos    (st_q.cnt),
        .sel_bit(sel_bit)
    );

    always_comb begin
        if (strobe_hi) begin
            data_bit = live[0];
        end else if (armed) begin
            data_bit = sel_bit;
        end else begin
            data_bit = 1'b0;
        end
    end

    // R7: the position never runs past the end of the frame
    assert_cnt_in_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LAST_POS);

    // R2: a capture restarts the frame
    assert_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        latch_evt |=> (st_q.cnt == '0));

    // R8: a held strobe keeps the frame at its first position
    assert_hold_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_hi |=> (st_q.cnt == '0));

    // R9: unselected pads never move the frame
    assert_frozen_unarmed_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !strobe_hi && !latch_evt) |=> $stable(st_q.cnt));

    // R10: without a read of this port its position stays put
    assert_no_read_no_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en && !strobe_hi && !latch_evt) |=> $stable(st_q.cnt));

    // R3: a selected read inside the frame moves exactly one position
    assert_single_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && armed && !strobe_hi && !latch_evt && (st_q.cnt < LAST_POS))
        |=> (st_q.cnt == $past(st_q.cnt) + 1'b1));

    // R11: captured pad values only change at a capture
    assert_shadow_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_evt |=> $stable(st_q.shadow));

endmodule

// File: rtl/padport_top.sv
module padport_top
    import padport_pkg::*;
#(
    parameter int BTN_W     = DEF_BTN_W,
    parameter int PADS_PORT = DEF_PADS_PORT,
    parameter int NUM_PORTS = DEF_NUM_PORTS,
    parameter int SIG_W     = DEF_SIG_W,
    parameter int FRAME_LEN = DEF_FRAME_LEN,
    localparam int ALL_W    = BTN_W * PADS_PORT * NUM_PORTS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 wr_d0,
    input  logic [NUM_PORTS-1:0] rd_en,
    input  logic [ALL_W-1:0]     pad_buttons,
    input  logic [NUM_PORTS-1:0] pad_present,
    output logic [NUM_PORTS-1:0] port_bit
);

    logic strobe_hi;
    logic armed;
    logic latch_evt;

    padport_strobe_ctl i_strobe (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_d0    (wr_d0),
        .strobe_hi(strobe_hi),
        .armed    (armed),
        .latch_evt(latch_evt)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        padport_lane #(
            .PORT_IDX (p),
            .BTN_W    (BTN_W),
            .PADS_PORT(PADS_PORT),
            .NUM_PORTS(NUM_PORTS),
            .SIG_W    (SIG_W),
            .FRAME_LEN(FRAME_LEN)
        ) i_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .pads_all (pad_buttons),
            .present  (pad_present[p]),
            .strobe_hi(strobe_hi),
            .armed    (armed),
            .latch_evt(latch_evt),
            .rd_en    (rd_en[p]),
            .data_bit (port_bit[p])
        );
    end

    // R1: unselected pads with the strobe low present nothing on any port
    assert_quiet_unarmed_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_hi && !armed) |-> (port_bit == '0));

endmodule

// File: tb/test_padport_top.sv
module test_padport_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_d0 = 1'b0;
    logic [1:0]  rd_en = '0;
    logic [31:0] pad_buttons = '0;
    logic [1:0]  pad_present = '0;
    logic [1:0]  port_bit;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    padport_top i_padport_top (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_d0      (wr_d0),
        .rd_en      (rd_en),
        .pad_buttons(pad_buttons),
        .pad_present(pad_present),
        .port_bit   (port_bit)
    );

    // {present[1:0], pads 3..0}
    localparam logic [33:0] VECS [4] = '{
        {2'b11, 32'h817E_C35A},
        {2'b01, 32'hFF00_0FF0},
        {2'b10, 32'h1234_5678},
        {2'b00, 32'hFFFF_FFFF}
    };

    function automatic logic exp_bit(input int p, input int idx,
                                     input logic [31:0] pads, input logic [1:0] pres);
        logic [3:0] code;
        code = 4'(1 << p);
        if (idx < 8)  return pads[p*8 + idx];
        if (idx < 16) return pads[(p+2)*8 + idx - 8];
        if (idx < 20) return pres[p] ? code[3 - (idx - 16)] : 1'b0;
        return 1'b0;
    endfunction

    task automatic check(input string tag, input logic got, input logic expv);
        n_checks++;
        if (got !== expv) begin
            n_fail++;
            $display("FAIL %s got %0b expected %0b", tag, got, expv);
        end
    endtask

    task automatic do_write(input logic b);
        @(negedge clk);
        wr_en = 1'b1;
        wr_d0 = b;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic full_strobe();
        do_write(1'b1);
        do_write(1'b0);
    endtask

    task automatic do_read(input int p, output logic got);
        @(negedge clk);
        rd_en    = '0;
        rd_en[p] = 1'b1;
        #2 got = port_bit[p];
        @(posedge clk);
        #1 rd_en = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic g;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        pad_buttons = 32'h0000_0201;
        pad_present = 2'b11;
        @(negedge clk);
        #2;
        check("R1 port0 after reset", port_bit[0], 1'b0);
        check("R1 port1 after reset", port_bit[1], 1'b0);
        for (int i = 0; i < 3; i++) begin
            do_read(0, g);
            check("R1 read before strobe", g, 1'b0);
        end

        // vector table walk: both ports interleaved, past the frame end
        for (int v = 0; v < 4; v++) begin
            pad_buttons = VECS[v][31:0];
            pad_present = VECS[v][33:32];
            full_strobe();
            for (int idx = 0; idx < 27; idx++) begin
                for (int p = 0; p < 2; p++) begin
                    do_read(p, g);
                    if (idx < 16)
                        check(idx < 8 ? "R3 first pad" : "R4 second pad", g,
                              exp_bit(p, idx, VECS[v][31:0], VECS[v][33:32]));
                    else if (idx < 20)
                        check(VECS[v][32+p] ? "R5 code" : "R6 absent code", g,
                              exp_bit(p, idx, VECS[v][31:0], VECS[v][33:32]));
                    else
                        check("R7 fill", g, 1'b0);
                end
            end
        end

        // R8: live button A while strobe held high
        pad_present = 2'b11;
        pad_buttons = 32'h0000_0001;
        do_write(1'b1);
        do_read(0, g);
        check("R8 live A high", g, 1'b1);
        pad_buttons = 32'h0000_0100;
        do_read(0, g);
        check("R8 live A dropped", g, 1'b0);
        do_read(1, g);
        check("R8 port1 live A", g, 1'b1);
        pad_buttons = 32'h0000_0001;
        do_write(1'b0);
        // R11: change inputs after capture
        pad_buttons = 32'hFFFF_FFFE;
        do_read(0, g);
        check("R8 first position after hold R11", g, 1'b1);
        do_read(0, g);
        check("R11 captured B", g, 1'b0);

        // R10: port0 reads do not advance port1
        pad_buttons = 32'h0000_0200;
        full_strobe();
        for (int i = 0; i < 5; i++) do_read(0, g);
        do_read(1, g);
        check("R10 port1 still at A", g, 1'b0);
        do_read(1, g);
        check("R10 port1 B", g, 1'b1);

        // R9: stray clear write unselects pads
        pad_buttons = 32'h0000_00FF;
        full_strobe();
        do_read(0, g);
        check("R9 selected before stray", g, 1'b1);
        do_write(1'b0);
        for (int i = 0; i < 3; i++) begin
            do_read(0, g);
            check("R9 unselected read", g, 1'b0);
        end
        pad_buttons = 32'h0000_0002;
        full_strobe();
        do_read(0, g);
        check("R9 recovery A", g, 1'b0);
        do_read(0, g);
        check("R9 recovery B", g, 1'b1);

        // R7: long run of reads past the end
        full_strobe();
        for (int i = 0; i < 40; i++) begin
            do_read(0, g);
            if (i >= 20) check("R7 beyond frame", g, 1'b0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule